// File: doc/BRIEF.md
# Configurable Parallel-Prefix Adder

This block is a purely combinational adder of `WIDTH` bits with a carry input and a carry output. The carries come from a radix-2 parallel-prefix network. That network has logarithmic depth and unbounded fanout, and at each level the upper half of every block of positions takes the group of the last position in the lower half. The carry input enters the network as an extra position below bit 0, so every prefix result is a resolved carry.

Two independent parameters shape the logic on top of this one graph. `ENC` picks the form of each prefix pair. It is either generate/propagate, combined with AND-OR logic, or the pair of group carries for an incoming carry of 0 and of 1, combined with multiplexers. `SUM_MODE` picks how each sum bit is formed. In lookahead mode each sum bit is the XOR of its half-sum and its carry. In select mode both candidate sum bits are prepared ahead of time and the carry from the prefix network picks one of them. The block is placed where a datapath needs a fast final carry-propagate addition and the integrator wants to trade cell types without touching the surrounding code.

Top module: `pfx_adder`

## Requirements
- R1: With generate/propagate pairs and lookahead sums, `{cout_o, sum_o}` equals the (WIDTH+1)-bit value `a_i + b_i + cin_i` for every input combination.
- R2: With generate/propagate pairs and select sums, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` for every input combination.
- R3: With carry-pair (multiplexer) encoding and lookahead sums, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` for every input combination.
- R4: With carry-pair encoding and select sums, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` for every input combination.
- R5: A carry input of 1 propagates through the full width. With `a_i` all ones, `b_i` zero and `cin_i` 1, `sum_o` is zero and `cout_o` is 1. With `cin_i` 0 under the same operands, `sum_o` is all ones and `cout_o` is 0.
- R6: `cout_o` is 1 exactly when the true sum is at least 2^WIDTH. The cases are: all ones plus all ones plus 1 gives all-ones sum and carry 1; all ones plus 1 gives zero and carry 1; all ones plus 0 gives carry 0.
- R7: The block holds no state. Outputs are valid in the same evaluation in which the inputs change, with zero clock cycles of latency, and all-zero inputs give a zero sum and a zero carry out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry input, weight 1 |
| sum_o | output | WIDTH | Low WIDTH bits of the sum |
| cout_o | output | 1 | Carry output, weight 2^WIDTH |

## Verification
Every result of this adder is due in the same evaluation as its stimulus, zero clock cycles after the input change. The bench therefore applies each operand set and waits one nanosecond of settling before it compares all configured instances against an arithmetic reference. At 8 bits it sweeps every operand and carry combination on four instances, one per parameter pair. At 32 bits it runs pseudo-random and directed carry-chain vectors through another four instances.

// File: rtl/pfx_adder_pkg.sv
package pfx_adder_pkg;

    typedef enum logic {
        ENC_GP  = 1'b0,
        ENC_MUX = 1'b1
    } pfx_enc_e;

    typedef enum logic {
        SUM_LOOKAHEAD = 1'b0,
        SUM_SELECT    = 1'b1
    } sum_mode_e;

    // GP encoding : x = group generate, y = group propagate
    // MUX encoding: x = group carry for incoming 0, y = for incoming 1
    typedef struct packed {
        logic x;
        logic y;
    } pfx_pair_t;

    function automatic pfx_pair_t pair_leaf(pfx_enc_e enc, logic a, logic b);
        pfx_pair_t r;
        if (enc == ENC_GP) begin
            r.x = a & b;
            r.y = a ^ b;
        end else begin
            r.x = a & b;
            r.y = a | b;
        end
        return r;
    endfunction

    function automatic pfx_pair_t pair_seed(pfx_enc_e enc, logic cin);
        pfx_pair_t r;
        r.x = cin;
        r.y = (enc == ENC_GP) ? 1'b0 : cin;
        return r;
    endfunction

    function automatic pfx_pair_t pair_join(pfx_enc_e enc, pfx_pair_t hi, pfx_pair_t lo);
        pfx_pair_t r;
        if (enc == ENC_GP) begin
            r.x = hi.x | (hi.y & lo.x);
            r.y = hi.y & lo.y;
        end else begin
            r.x = lo.x ? hi.y : hi.x;
            r.y = lo.y ? hi.y : hi.x;
        end
        return r;
    endfunction

endpackage

// File: rtl/pfx_leaf.sv
module pfx_leaf
    import pfx_adder_pkg::*;
#(
    parameter int       WIDTH = 32,
    parameter pfx_enc_e ENC   = ENC_GP
) (
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    input  logic              cin_i,
    output pfx_pair_t [WIDTH:0] pair_o,
    output logic [WIDTH-1:0]  half_o
);

    assign pair_o[0] = pair_seed(ENC, cin_i);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pair_o[i+1] = pair_leaf(ENC, a_i[i], b_i[i]);
        assign half_o[i]   = a_i[i] ^ b_i[i];

        if (ENC == ENC_GP) begin : g_chk
            always_comb begin
                // R1: a bit cannot both generate and propagate
                a_r1_leaf_exclusive: assert (!(pair_o[i+1].x && pair_o[i+1].y))
                    else $error("leaf %0d generates and propagates", i);
            end
        end
    end

endmodule

// File: rtl/pfx_tree.sv
module pfx_tree
    import pfx_adder_pkg::*;
#(
    parameter int       WIDTH = 32,
    parameter pfx_enc_e ENC   = ENC_GP
) (
    input  pfx_pair_t [WIDTH:0] leaf_i,
    output logic [WIDTH:0]      carry_o
);

    localparam int NPOS = WIDTH + 1;
    localparam int LVLS = (NPOS > 1) ? $clog2(NPOS) : 1;

    pfx_pair_t [WIDTH:0] stage [0:LVLS];

    assign stage[0] = leaf_i;

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        for (genvar j = 0; j < NPOS; j++) begin : g_pos
            if (((j >> l) & 1) == 1) begin : g_node
                localparam int SRC = ((j >> (l + 1)) << (l + 1)) + (1 << l) - 1;
                assign stage[l+1][j] = pair_join(ENC, stage[l][j], stage[l][SRC]);
            end else begin : g_pass
                assign stage[l+1][j] = stage[l][j];
            end
        end
    end

    for (genvar j = 0; j < NPOS; j++) begin : g_out
        assign carry_o[j] = stage[LVLS][j].x;

        if (ENC == ENC_GP) begin : g_chk_gp
            always_comb begin
                // R1 R2: groups reaching the carry input never propagate
                a_r1_group_prop_clear: assert (stage[LVLS][j].y == 1'b0)
                    else $error("position %0d still propagates", j);
            end
        end else begin : g_chk_mux
            always_comb begin
                // R3 R4: both carry candidates agree once the carry input is folded in
                a_r3_pair_resolved: assert (stage[LVLS][j].x == stage[LVLS][j].y)
                    else $error("position %0d carry pair unresolved", j);
            end
        end
    end

endmodule

// File: rtl/pfx_sum.sv
module pfx_sum
    import pfx_adder_pkg::*;
#(
    parameter int        WIDTH    = 32,
    parameter sum_mode_e SUM_MODE = SUM_LOOKAHEAD
) (
    input  logic [WIDTH-1:0] half_i,
    input  logic [WIDTH-1:0] carry_i,
    output logic [WIDTH-1:0] sum_o
);

    if (SUM_MODE == SUM_LOOKAHEAD) begin : g_la
        assign sum_o = half_i ^ carry_i;
    end else begin : g_sel
        logic [WIDTH-1:0] cand0;
        logic [WIDTH-1:0] cand1;
        assign cand0 = half_i;
        assign cand1 = ~half_i;
        for (genvar i = 0; i < WIDTH; i++) begin : g_mux
            assign sum_o[i] = carry_i[i] ? cand1[i] : cand0[i];
        end
    end

endmodule

// File: rtl/pfx_adder.sv
module pfx_adder
    import pfx_adder_pkg::*;
#(
    parameter int        WIDTH    = 32,
    parameter pfx_enc_e  ENC      = ENC_GP,
    parameter sum_mode_e SUM_MODE = SUM_LOOKAHEAD
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    pfx_pair_t [WIDTH:0] leaf_pairs;
    logic [WIDTH-1:0]    half;
    logic [WIDTH:0]      carries;

    pfx_leaf #(.WIDTH(WIDTH), .ENC(ENC)) u_leaf (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .pair_o (leaf_pairs),
        .half_o (half)
    );

    pfx_tree #(.WIDTH(WIDTH), .ENC(ENC)) u_tree (
        .leaf_i  (leaf_pairs),
        .carry_o (carries)
    );

    pfx_sum #(.WIDTH(WIDTH), .SUM_MODE(SUM_MODE)) u_sum (
        .half_i  (half),
        .carry_i (carries[WIDTH-1:0]),
        .sum_o   (sum_o)
    );

    assign cout_o = carries[WIDTH];

    always_comb begin
        // R1 R2 R3 R4 R6: ports agree with an arithmetic sum
        a_r6_exact_sum: assert ({cout_o, sum_o} ==
                                ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
            else $error("sum mismatch");
    end

endmodule

// File: tb/sim_pfx_adder.sv
`timescale 1ns/1ps
module sim_pfx_adder;
    import pfx_adder_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W8  = 8;
    localparam int W32 = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [W8-1:0]  a8 = '0, b8 = '0;
    logic [W32-1:0] a32 = '0, b32 = '0;
    logic           c8 = 1'b0, c32 = 1'b0;

    logic [W8-1:0]  s8  [4];
    logic           co8 [4];
    logic [W32-1:0] s32 [4];
    logic           co32[4];

    pfx_adder #(.WIDTH(W8), .ENC(ENC_GP),  .SUM_MODE(SUM_LOOKAHEAD)) u0 (.a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8[0]), .cout_o(co8[0]));
    pfx_adder #(.WIDTH(W8), .ENC(ENC_GP),  .SUM_MODE(SUM_SELECT))    u1 (.a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8[1]), .cout_o(co8[1]));
    pfx_adder #(.WIDTH(W8), .ENC(ENC_MUX), .SUM_MODE(SUM_LOOKAHEAD)) u2 (.a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8[2]), .cout_o(co8[2]));
    pfx_adder #(.WIDTH(W8), .ENC(ENC_MUX), .SUM_MODE(SUM_SELECT))    u3 (.a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8[3]), .cout_o(co8[3]));

    pfx_adder #(.WIDTH(W32), .ENC(ENC_GP),  .SUM_MODE(SUM_LOOKAHEAD)) u4 (.a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32[0]), .cout_o(co32[0]));
    pfx_adder #(.WIDTH(W32), .ENC(ENC_GP),  .SUM_MODE(SUM_SELECT))    u5 (.a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32[1]), .cout_o(co32[1]));
    pfx_adder #(.WIDTH(W32), .ENC(ENC_MUX), .SUM_MODE(SUM_LOOKAHEAD)) u6 (.a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32[2]), .cout_o(co32[2]));
    pfx_adder #(.WIDTH(W32), .ENC(ENC_MUX), .SUM_MODE(SUM_SELECT))    u7 (.a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32[3]), .cout_o(co32[3]));

    function automatic string cfg_tag(int k);
        case (k)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(string req, logic [W32:0] got, logic [W32:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic chk_all8(string extra);
        logic [W8:0] exp = {1'b0, a8} + {1'b0, b8} + {8'b0, c8};
        for (int k = 0; k < 4; k++)
            chk({cfg_tag(k), extra}, {24'b0, co8[k], s8[k]}, {24'b0, exp});
    endtask

    task automatic chk_all32(string extra);
        logic [W32:0] exp = {1'b0, a32} + {1'b0, b32} + {32'b0, c32};
        for (int k = 0; k < 4; k++)
            chk({cfg_tag(k), extra}, {co32[k], s32[k]}, exp);
    endtask

    // R7: no state, zero inputs give zero outputs in the same evaluation
    task automatic t_idle();
        a8 = '0; b8 = '0; c8 = 1'b0; a32 = '0; b32 = '0; c32 = 1'b0;
        #1;
        for (int k = 0; k < 4; k++) begin
            chk("R7 zero8", {24'b0, co8[k], s8[k]}, '0);
            chk("R7 zero32", {co32[k], s32[k]}, '0);
        end
        a32 = 32'h0000_00F0; b32 = 32'h0000_0010; c32 = 1'b0;
        #1;
        chk("R7 same-eval", {co32[0], s32[0]}, 33'h0_0000_0100);
    endtask

    // R1 R2 R3 R4: every operand and carry pair at 8 bits
    task automatic t_exhaustive8();
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                for (int c = 0; c < 2; c++) begin
                    a8 = a[7:0]; b8 = b[7:0]; c8 = c[0];
                    #1;
                    chk_all8(" exh8");
                end
    endtask

    // R1 R2 R3 R4: pseudo-random operands at 32 bits
    task automatic t_random32();
        logic [31:0] st = 32'h1234_5678;
        for (int n = 0; n < 4000; n++) begin
            st ^= st << 13; st ^= st >> 17; st ^= st << 5;
            a32 = st;
            st ^= st << 13; st ^= st >> 17; st ^= st << 5;
            b32 = st;
            c32 = st[7];
            #1;
            chk_all32(" rnd32");
        end
    endtask

    // R5: carry input ripples across the full width
    task automatic t_carry_chain();
        a32 = '1; b32 = '0; c32 = 1'b1; #1;
        for (int k = 0; k < 4; k++) chk("R5 chain32 cin1", {co32[k], s32[k]}, {1'b1, 32'h0});
        c32 = 1'b0; #1;
        for (int k = 0; k < 4; k++) chk("R5 chain32 cin0", {co32[k], s32[k]}, {1'b0, 32'hFFFF_FFFF});
        a32 = 32'h5555_5555; b32 = 32'hAAAA_AAAA; c32 = 1'b1; #1;
        for (int k = 0; k < 4; k++) chk("R5 alt32", {co32[k], s32[k]}, {1'b1, 32'h0});
        a8 = '1; b8 = '0; c8 = 1'b1; #1;
        for (int k = 0; k < 4; k++) chk("R5 chain8", {24'b0, co8[k], s8[k]}, {24'b0, 9'h100});
    endtask

    // R6: carry out boundary
    task automatic t_overflow();
        a32 = '1; b32 = '1; c32 = 1'b1; #1;
        for (int k = 0; k < 4; k++) chk("R6 max+max+1", {co32[k], s32[k]}, {1'b1, 32'hFFFF_FFFF});
        a32 = '1; b32 = 32'd1; c32 = 1'b0; #1;
        for (int k = 0; k < 4; k++) chk("R6 max+1", {co32[k], s32[k]}, {1'b1, 32'h0});
        a32 = '1; b32 = '0; c32 = 1'b0; #1;
        for (int k = 0; k < 4; k++) chk("R6 max+0", {co32[k], s32[k]}, {1'b0, 32'hFFFF_FFFF});
        a32 = 32'h8000_0000; b32 = 32'h7FFF_FFFF; c32 = 1'b0; #1;
        for (int k = 0; k < 4; k++) chk("R6 just-below", {co32[k], s32[k]}, {1'b0, 32'hFFFF_FFFF});
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/4);
        rst = 1'b0;
        t_idle();
        t_exhaustive8();
        t_random32();
        t_carry_chain();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule